// File: doc/BRIEF.md
# Pixel Clock Enable Divider With Bypass

This block turns a free-running reference clock into a single-cycle pixel clock enable pulse at a programmable lower rate. It does not create a new clock. Downstream logic stays on the reference clock and advances only on cycles where the enable is high. The rate comes from a 32-bit configuration word. A divisor field in that word is split into a low part and a high part, and a separate bypass bit selects the full reference rate. The divisor is stored as the real divide ratio minus two, so divide-by-one can only be reached through the bypass bit.

The block has a combinational word encoder. It takes the current configuration word and a requested divide ratio, and it returns an updated word. Only the divisor and bypass bits change; every other bit keeps its value. Software or a rate-selection block can write that word back. Once running, a new divisor takes effect only at the end of the period in progress, so a short period is never produced. A readback port shows the divisor in force for the current period.

Top module: `pcd_pixclk_div`

## Requirements
- R1: When bit 26 (bypass) of `cfg_word` is set, the enable runs at the reference rate: it is high on every cycle, `div_now` reads 1, and the values in the divisor fields have no effect.
- R2: When bypass is clear, the effective divisor is the 10-bit field value plus 2, and `pix_en` is high for one cycle out of every divisor cycles.
- R3: The 10-bit field is formed with `cfg_word[31:27]` as its upper five bits and `cfg_word[4:0]` as its lower five bits, so a word with only bit 27 set gives a divisor of 34.
- R4: The encoder answers a requested ratio of 0 or 1 by setting bit 26 and clearing both field parts.
- R5: The encoder answers a requested ratio N of 2 or more by clearing bit 26 and storing N-2 split across the two parts. Requests above 1025 are clamped to 1025, which is stored as an all-ones field.
- R6: The encoder leaves bits [25:5] of the word unchanged.
- R7: A change in `cfg_word` is sampled only on a cycle where `pix_en` is high, and the new divisor governs the period that follows, so every period has exactly the length of the divisor in force when it began.
- R8: `div_now` reports the divisor governing the current period. Out of reset it reads 1 and `pix_en` is high on the first cycle, which loads the configured divisor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | 32 | Configuration word: field parts and bypass bit |
| req_div | input | 11 | Requested divide ratio for the encoder |
| cfg_word_upd | output | 32 | `cfg_word` with the divisor and bypass bits rewritten for `req_div` |
| pix_en | output | 1 | Single-cycle pixel clock enable |
| div_now | output | 11 | Divisor governing the current period |

## Verification
Some properties are checked by assertions on every cycle. The counter always stays below the divisor in force. The divisor changes only on a pulse cycle. A divisor of one forces the enable high. After each pulse, the readback equals the decoded word from the cycle before. The encoder keeps the unrelated bits and never produces a decoded divisor below two without bypass. Other behaviour can only be shown by the bench scenarios: the actual pulse spacing, the placement of the high field part, the clamp of oversized requests, and a change made mid-period being deferred. The bench shows these by comparing every cycle against a behavioural counter model.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  localparam int LO_W_D   = 5;
  localparam int HI_W_D   = 5;
  localparam int LO_POS_D = 0;
  localparam int HI_POS_D = 27;
  localparam int BYP_POS_D = 26;
  localparam int FLD_W_D  = LO_W_D + HI_W_D;
  localparam int MAX_DIV_D = (1 << FLD_W_D) + 1;
  localparam int DIV_W_D  = $clog2(MAX_DIV_D + 1);
endpackage

// File: rtl/pcd_decode.sv
module pcd_decode #(
  parameter int LO_W    = pcd_pkg::LO_W_D,
  parameter int HI_W    = pcd_pkg::HI_W_D,
  parameter int LO_POS  = pcd_pkg::LO_POS_D,
  parameter int HI_POS  = pcd_pkg::HI_POS_D,
  parameter int BYP_POS = pcd_pkg::BYP_POS_D,
  parameter int DIV_W   = pcd_pkg::DIV_W_D
) (
  input  logic [31:0]      word,
  output logic             byp,
  output logic [DIV_W-1:0] div
);
  localparam int FLD_W = LO_W + HI_W;

  // joins the two field parts, high part on top
  function automatic logic [FLD_W-1:0] join_fld(input logic [31:0] w);
    logic [FLD_W-1:0] f;
    for (int i = 0; i < LO_W; i++) f[i] = w[LO_POS + i];
    for (int i = 0; i < HI_W; i++) f[LO_W + i] = w[HI_POS + i];
    return f;
  endfunction

  function automatic logic [DIV_W-1:0] fld_to_div(input logic [FLD_W-1:0] f);
    return DIV_W'(f) + DIV_W'(2);
  endfunction

  always_comb begin
    byp = word[BYP_POS];
    div = byp ? DIV_W'(1) : fld_to_div(join_fld(word));
  end

  always_comb begin
    a_r2_div_floor: assert (byp || div >= DIV_W'(2));
  end
endmodule

// File: rtl/pcd_encode.sv
module pcd_encode #(
  parameter int LO_W    = pcd_pkg::LO_W_D,
  parameter int HI_W    = pcd_pkg::HI_W_D,
  parameter int LO_POS  = pcd_pkg::LO_POS_D,
  parameter int HI_POS  = pcd_pkg::HI_POS_D,
  parameter int BYP_POS = pcd_pkg::BYP_POS_D,
  parameter int DIV_W   = pcd_pkg::DIV_W_D
) (
  input  logic [31:0]      word_in,
  input  logic [DIV_W-1:0] req,
  output logic [31:0]      word_out
);
  localparam int FLD_W   = LO_W + HI_W;
  localparam int MAX_DIV = (1 << FLD_W) + 1;

  function automatic logic [31:0] owned_mask();
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < LO_W; i++) m[LO_POS + i] = 1'b1;
    for (int i = 0; i < HI_W; i++) m[HI_POS + i] = 1'b1;
    m[BYP_POS] = 1'b1;
    return m;
  endfunction

  function automatic logic [FLD_W-1:0] req_to_fld(input logic [DIV_W-1:0] r);
    logic [DIV_W-1:0] c;
    c = (r > DIV_W'(MAX_DIV)) ? DIV_W'(MAX_DIV) : r;
    return FLD_W'(c - DIV_W'(2));
  endfunction

  function automatic logic [31:0] place(input logic [DIV_W-1:0] r);
    logic [31:0] w;
    logic [FLD_W-1:0] f;
    w = '0;
    if (r <= DIV_W'(1)) begin
      w[BYP_POS] = 1'b1;
    end else begin
      f = req_to_fld(r);
      for (int i = 0; i < LO_W; i++) w[LO_POS + i] = f[i];
      for (int i = 0; i < HI_W; i++) w[HI_POS + i] = f[LO_W + i];
    end
    return w;
  endfunction

  logic [31:0] keep_mask;
  logic [31:0] new_bits;

  always_comb begin
    keep_mask = ~owned_mask();
    new_bits  = place(req);
    word_out  = (word_in & keep_mask) | new_bits;
  end

  always_comb begin
    a_r6_keep_other: assert ((word_out & keep_mask) == (word_in & keep_mask));
    a_r4_byp_clean:  assert (!(req <= DIV_W'(1)) || new_bits[BYP_POS]);
  end
endmodule

// File: rtl/pcd_tick_gen.sv
module pcd_tick_gen #(
  parameter int DIV_W = pcd_pkg::DIV_W_D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] next_div,
  output logic             en,
  output logic [DIV_W-1:0] cur_div
);
  logic [DIV_W-1:0] cnt;
  logic             period_end;

  assign period_end = (cnt == cur_div - DIV_W'(1));
  assign en = period_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      cur_div <= DIV_W'(1);
    end else if (period_end) begin
      cnt     <= '0;
      cur_div <= next_div;
    end else begin
      cnt     <= cnt + DIV_W'(1);
    end
  end

  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < cur_div);
  a_r7_hold_mid: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cur_div));
  a_r1_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_div == DIV_W'(1)) |-> en);
endmodule

// File: rtl/pcd_pixclk_div.sv
module pcd_pixclk_div #(
  parameter int LO_W    = pcd_pkg::LO_W_D,
  parameter int HI_W    = pcd_pkg::HI_W_D,
  parameter int LO_POS  = pcd_pkg::LO_POS_D,
  parameter int HI_POS  = pcd_pkg::HI_POS_D,
  parameter int BYP_POS = pcd_pkg::BYP_POS_D,
  parameter int DIV_W   = $clog2((1 << (LO_W + HI_W)) + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      cfg_word,
  input  logic [DIV_W-1:0] req_div,
  output logic [31:0]      cfg_word_upd,
  output logic             pix_en,
  output logic [DIV_W-1:0] div_now
);
  logic             cfg_byp;
  logic [DIV_W-1:0] cfg_div;

  pcd_decode #(.LO_W(LO_W), .HI_W(HI_W), .LO_POS(LO_POS), .HI_POS(HI_POS),
               .BYP_POS(BYP_POS), .DIV_W(DIV_W)) u_dec (
    .word(cfg_word), .byp(cfg_byp), .div(cfg_div));

  pcd_encode #(.LO_W(LO_W), .HI_W(HI_W), .LO_POS(LO_POS), .HI_POS(HI_POS),
               .BYP_POS(BYP_POS), .DIV_W(DIV_W)) u_enc (
    .word_in(cfg_word), .req(req_div), .word_out(cfg_word_upd));

  pcd_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .next_div(cfg_div),
    .en(pix_en), .cur_div(div_now));

  a_r8_readback_load: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en |=> div_now == $past(cfg_div));
  a_r1_byp_one: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && cfg_byp) |=> div_now == DIV_W'(1));
endmodule

// File: tb/tb_pcd_pixclk_div.sv
module tb_pcd_pixclk_div;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [31:0]   cfg_word = 32'h0;
  logic [DW-1:0] req_div = '0;
  logic [31:0]   cfg_word_upd;
  logic          pix_en;
  logic [DW-1:0] div_now;

  int checks = 0;
  int fails = 0;
  int m_act = 1;
  int m_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcd_pixclk_div dut (.clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
    .req_div(req_div), .cfg_word_upd(cfg_word_upd), .pix_en(pix_en),
    .div_now(div_now));

  function automatic int ref_div(input logic [31:0] w);
    if (w[26]) return 1;
    return ((w >> 27) & 32'h1F) * 32 + (w & 32'h1F) + 2;
  endfunction

  function automatic logic [31:0] ref_enc(input logic [31:0] w, input int r);
    logic [31:0] m;
    int f;
    m = 32'hFC00_001F;
    if (r <= 1) return (w & ~m) | 32'h0400_0000;
    if (r > 1025) r = 1025;
    f = r - 2;
    return (w & ~m) | (f & 31) | ((f / 32) << 27);
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural model: one counter, one divisor, loaded on each pulse
  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 1; m_cnt = 0;
    end else if (m_cnt == m_act - 1) begin
      m_cnt = 0; m_act = ref_div(cfg_word);
    end else begin
      m_cnt++;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 R7 pix_en vs model", pix_en, (m_cnt == m_act - 1));
      chk("R8 div_now vs model", div_now, m_act);
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enc_chk(input logic [31:0] w, input int r, input string tag);
    @(negedge clk);
    cfg_word = w; req_div = DW'(r);
    #1;
    chk(tag, cfg_word_upd, ref_enc(w, r));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset div_now", div_now, 1);
    rst_n = 1'b1;
    // first cycle after reset: pulse, loads the configured divisor
    chk("R8 first pulse", pix_en, 1);
    cfg_word = 32'h0000_0003;           // divisor 5
    run(30);
    cfg_word = 32'hFFFF_FFFF;           // bypass, fields all ones: R1
    run(12);
    chk("R1 bypass readback", div_now, 1);
    chk("R1 bypass pulse", pix_en, 1);
    cfg_word = 32'h0800_0000;           // only bit 27: R3 divisor 34
    run(80);
    chk("R3 high part", div_now, 34);
    cfg_word = 32'h0000_0000;           // divisor 2
    run(80);
    cfg_word = 32'h0000_0008;           // divisor 10
    run(14);
    cfg_word = 32'h0000_0001;           // mid-period change to 3: R7
    run(30);
    cfg_word = 32'hF800_001F;           // largest divisor 1025
    run(2200);
    chk("R2 max divisor", div_now, 1025);
    cfg_word = 32'h03FF_FFE0;           // unrelated bits only: divisor 2
    run(1100);
    enc_chk(32'h03FF_FFE0, 1, "R4 encode 1");
    enc_chk(32'h1234_5678, 0, "R4 encode 0");
    enc_chk(32'h0000_0000, 2, "R5 encode 2");
    enc_chk(32'h5555_5555, 34, "R5 encode 34");
    enc_chk(32'hAAAA_AAAA, 2047, "R5 clamp");
    enc_chk(32'hFFFF_FFFF, 700, "R6 keep bits");
    #1 chk("R6 middle bits", cfg_word_upd & 32'h03FF_FFE0, 32'h03FF_FFE0);
    run(4);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule